// File: doc/BRIEF.md
# Clock Request Output Gating

This block decides, for every differential reference-clock output of a clock generator, whether that output is driven or held in its high-impedance state. It merges three sources: one enable bit per output from the control registers, a small set of active-low clock-request pins, and a board strap. The strap is captured once after reset. It decides whether two shared pins serve as request inputs or as one more clock pair.

Each request pin is steered to one output by an index field held in a control register. When the strap is captured low, a deasserted request (pin high) turns off the output it is steered to. That output's own enable bit is then ignored. The shared output position is forced off in this case, because its pins are in use as inputs. When the strap is captured high, the request pins are ignored and the shared output follows its enable bit like any other output. A power-down input overrides everything. Request pins pass through a synchroniser before they take effect. The final enables are registered, so they change only on a clock edge.

Top module: `cgate_out_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `out_en` is 0 and every bit of `out_hiz` is 1.
- R2: Requests are active low. With the strap captured 0, an output whose register enable is 1 is driven only if every request steered to it is low. A high request turns that output off.
- R3: Request A is `req_n[0]` and its field is `map_sel[2:0]`. Request B is `req_n[1]` and its field is `map_sel[5:3]`. Each field holds the binary number of the output it gates. Power-up values are A=4 and B=5, under which A gates output 4 and B gates output 5.
- R4: Writing a new field value moves the gating to the new output. The output that was gated before then follows only its own register enable.
- R5: With the strap captured 0, output `SHARED_IDX` (default 6) stays off whatever its register enable.
- R6: With the strap captured 1, both request pins have no effect. Every output, output 6 included, follows its register enable bit.
- R7: The strap is sampled on the first clock edge after reset is released. Later changes of `strap_sel` have no effect until the next reset.
- R8: An output whose register enable bit is 0 is off, whatever its requests are.
- R9: While `pwr_down` is high every output is off, regardless of register and request state.
- R10: A change on a request pin reaches `out_en` on the third rising edge after it. A change of `reg_en`, `map_sel` or `pwr_down` reaches `out_en` on the next rising edge.
- R11: If both requests are steered to the same output, that output is driven only while both are low.
- R12: `out_hiz` is always the bitwise complement of `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_en | input | NUM_OUT | Per-output enable bits from the control registers |
| map_sel | input | NUM_REQ*IDX_W | Output index for each request, request 0 in the low bits |
| req_n | input | NUM_REQ | Asynchronous clock-request pins, active low |
| strap_sel | input | 1 | Shared-pin strap: 0 = request inputs, 1 = extra clock pair |
| pwr_down | input | 1 | Power-down, active high |
| out_en | output | NUM_OUT | Registered final enable per output |
| out_hiz | output | NUM_OUT | High-impedance control per output, complement of out_en |

## Verification
Register enables, field values and power-down are due one rising edge after they are applied. Request pins take three edges: two synchroniser stages and the output register. The strap takes effect on the second edge after reset release. The bench drives on falling edges. In the vector walk it waits four falling edges before sampling, which covers the slowest path. The latency tests sample on the falling edge right after the second and third rising edges, to confirm the request result is neither early nor late.

// File: rtl/cgate_pkg.sv
// Package: shared defaults for the clock-request output gating block.
// Assumes outputs are numbered 0..NUM_OUT-1 and requests 0..NUM_REQ-1.
package cgate_pkg;
    localparam int unsigned CG_NUM_OUT     = 8;
    localparam int unsigned CG_NUM_REQ     = 2;
    localparam int unsigned CG_SHARED_IDX  = 6;
    localparam int unsigned CG_SYNC_STAGES = 2;

    // Strap meaning once captured
    typedef enum logic {
        SHARED_AS_REQ = 1'b0,
        SHARED_AS_CLK = 1'b1
    } shared_mode_e;
endpackage

// File: rtl/cgate_req_sync.sv
// Module: multi-stage synchroniser for the active-low request pins.
// Assumes pins are asynchronous to clk; resets to the deasserted level (1).
module cgate_req_sync #(
    parameter int unsigned NUM_REQ = 2,
    parameter int unsigned STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] pin_n,
    output logic [NUM_REQ-1:0] sync_n
);
    logic [NUM_REQ-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
            // One synchroniser stage; stage 0 samples the pins
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '1;
                end else begin
                    if (s == 0) stage_q[s] <= pin_n;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/cgate_strap_latch.sv
// Module: one-shot capture of the shared-pin strap.
// Captures strap on the first edge after reset release; holds until reset.
module cgate_strap_latch
    import cgate_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_sel,
    output shared_mode_e mode,
    output logic         valid
);
    // Capture once, then freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= SHARED_AS_REQ;
            valid <= 1'b0;
        end else if (!valid) begin
            mode  <= shared_mode_e'(strap_sel);
            valid <= 1'b1;
        end
    end
endmodule

// File: rtl/cgate_en_logic.sv
// Module: combinational per-output enable decision.
// Assumes requests arrive already synchronised (active low).
module cgate_en_logic
    import cgate_pkg::*;
#(
    parameter int unsigned NUM_OUT    = 8,
    parameter int unsigned NUM_REQ    = 2,
    parameter int unsigned SHARED_IDX = 6,
    localparam int unsigned IDX_W     = $clog2(NUM_OUT)
) (
    input  logic [NUM_OUT-1:0]       reg_en,
    input  logic [NUM_REQ*IDX_W-1:0] map_sel,
    input  logic [NUM_REQ-1:0]       req_sync_n,
    input  shared_mode_e             mode,
    input  logic                     mode_valid,
    input  logic                     pwr_down,
    output logic [NUM_OUT-1:0]       en_next
);
    // blocked[i][r]: request r targets output i and is deasserted
    logic [NUM_REQ-1:0] blocked [NUM_OUT];

    generate
        for (genvar i = 0; i < int'(NUM_OUT); i++) begin : g_out
            for (genvar r = 0; r < int'(NUM_REQ); r++) begin : g_req
                // Decode whether request r holds output i off
                always_comb begin
                    blocked[i][r] = (mode == SHARED_AS_REQ) &&
                                    (map_sel[r*IDX_W +: IDX_W] == IDX_W'(i)) &&
                                    req_sync_n[r];
                end
            end

            // Merge register enable, requests, strap and power-down
            always_comb begin
                en_next[i] = reg_en[i] && !(|blocked[i]) && mode_valid && !pwr_down;
                if (i == int'(SHARED_IDX) && mode == SHARED_AS_REQ) begin
                    en_next[i] = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cgate_out_gate.sv
// Module: top of the clock-request output gating block.
// Registers final enables so outputs switch only on clk edges.
module cgate_out_gate
    import cgate_pkg::*;
#(
    parameter int unsigned NUM_OUT     = CG_NUM_OUT,
    parameter int unsigned NUM_REQ     = CG_NUM_REQ,
    parameter int unsigned SHARED_IDX  = CG_SHARED_IDX,
    parameter int unsigned SYNC_STAGES = CG_SYNC_STAGES,
    localparam int unsigned IDX_W      = $clog2(NUM_OUT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_OUT-1:0]       reg_en,
    input  logic [NUM_REQ*IDX_W-1:0] map_sel,
    input  logic [NUM_REQ-1:0]       req_n,
    input  logic                     strap_sel,
    input  logic                     pwr_down,
    output logic [NUM_OUT-1:0]       out_en,
    output logic [NUM_OUT-1:0]       out_hiz
);
    logic [NUM_REQ-1:0] req_sync_n;
    shared_mode_e       mode;
    logic               mode_valid;
    logic [NUM_OUT-1:0] en_next;
    logic [NUM_OUT-1:0] en_q;

    cgate_req_sync #(.NUM_REQ(NUM_REQ), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_n(req_n), .sync_n(req_sync_n)
    );

    cgate_strap_latch strap_i (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel),
        .mode(mode), .valid(mode_valid)
    );

    cgate_en_logic #(
        .NUM_OUT(NUM_OUT), .NUM_REQ(NUM_REQ), .SHARED_IDX(SHARED_IDX)
    ) logic_i (
        .reg_en(reg_en), .map_sel(map_sel), .req_sync_n(req_sync_n),
        .mode(mode), .mode_valid(mode_valid), .pwr_down(pwr_down),
        .en_next(en_next)
    );

    // Output enable register
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_next;
    end

    assign out_en  = en_q;
    assign out_hiz = ~en_q;
endmodule

// File: rtl/cgate_out_gate_chk.sv
// Module: assertion checker bound to cgate_out_gate.
// Observes ports plus synchroniser and strap-latch outputs.
module cgate_out_gate_chk
    import cgate_pkg::*;
#(
    parameter int unsigned NUM_OUT    = 8,
    parameter int unsigned NUM_REQ    = 2,
    parameter int unsigned SHARED_IDX = 6,
    localparam int unsigned IDX_W     = $clog2(NUM_OUT)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_OUT-1:0]       reg_en,
    input logic [NUM_REQ*IDX_W-1:0] map_sel,
    input logic [NUM_REQ-1:0]       req_sync_n,
    input shared_mode_e             mode,
    input logic                     mode_valid,
    input logic                     pwr_down,
    input logic [NUM_OUT-1:0]       out_en
);
    AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (out_en == '0)); // R9

    AST_REGEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((out_en & ~$past(reg_en)) == '0)); // R8

    AST_SHARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && mode == SHARED_AS_REQ) |=> !out_en[SHARED_IDX]); // R5

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |=> (mode_valid && $stable(mode))); // R7

    generate
        for (genvar r = 0; r < int'(NUM_REQ); r++) begin : g_req
            AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_valid && mode == SHARED_AS_REQ && req_sync_n[r])
                |=> !out_en[$past(map_sel[r*IDX_W +: IDX_W])]); // R2
        end
    endgenerate
endmodule

bind cgate_out_gate cgate_out_gate_chk #(
    .NUM_OUT(NUM_OUT), .NUM_REQ(NUM_REQ), .SHARED_IDX(SHARED_IDX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .map_sel(map_sel),
    .req_sync_n(req_sync_n), .mode(mode), .mode_valid(mode_valid),
    .pwr_down(pwr_down), .out_en(out_en)
);

// File: tb/cgate_out_gate_tb_top.sv
// Bench: vector walk under strap 0, then directed reset, latency and strap tests.
module cgate_out_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] reg_en;
    logic [5:0] map_sel;
    logic [1:0] req_n;
    logic       strap_sel;
    logic       pwr_down;
    logic [7:0] out_en;
    logic [7:0] out_hiz;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cgate_out_gate dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .map_sel(map_sel),
        .req_n(req_n), .strap_sel(strap_sel), .pwr_down(pwr_down),
        .out_en(out_en), .out_hiz(out_hiz)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [2:0] ma;
        logic [2:0] mb;
        logic [1:0] rq;
        logic       pd;
        logic [7:0] exp_en;
    } vec_t;

    // Strap captured 0: output 6 always off; rq[0]=A, rq[1]=B
    localparam vec_t VEC [10] = '{
        '{8'hFF, 3'd4, 3'd5, 2'b11, 1'b0, 8'h8F}, // R2 R3 both high
        '{8'hFF, 3'd4, 3'd5, 2'b00, 1'b0, 8'hBF}, // R2 R3 both low
        '{8'hFF, 3'd4, 3'd5, 2'b10, 1'b0, 8'h9F}, // R3 only A low
        '{8'hFF, 3'd4, 3'd5, 2'b01, 1'b0, 8'hAF}, // R3 only B low
        '{8'hFF, 3'd2, 3'd5, 2'b01, 1'b0, 8'hBB}, // R4 A moved to 2
        '{8'h0F, 3'd4, 3'd5, 2'b00, 1'b0, 8'h0F}, // R8 enables off
        '{8'hFF, 3'd3, 3'd3, 2'b01, 1'b0, 8'hB7}, // R11 one of two high
        '{8'hFF, 3'd3, 3'd3, 2'b00, 1'b0, 8'hBF}, // R11 both low
        '{8'hFF, 3'd4, 3'd5, 2'b00, 1'b1, 8'h00}, // R9 power-down
        '{8'hF0, 3'd0, 3'd7, 2'b00, 1'b0, 8'hB0}  // R5 R4 other indices
    };

    // Compare out_en and its complement
    task automatic check(input string req, input logic [7:0] exp_en);
        n_checks++;
        if (out_en !== exp_en || out_hiz !== ~exp_en) begin
            n_fail++;
            $display("FAIL %s: out_en=%h out_hiz=%h expected out_en=%h out_hiz=%h (R12)",
                     req, out_en, out_hiz, exp_en, ~exp_en);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; strap_sel = strap;
        wait_neg(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #200000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; strap_sel = 1'b0; reg_en = 8'hFF;
        map_sel = {3'd5, 3'd4}; req_n = 2'b00; pwr_down = 1'b0;
        wait_neg(3);
        check("R1 reset", 8'h00);
        rst_n = 1'b1;
        wait_neg(4);

        for (int v = 0; v < 10; v++) begin
            reg_en = VEC[v].en; map_sel = {VEC[v].mb, VEC[v].ma};
            req_n = VEC[v].rq; pwr_down = VEC[v].pd;
            wait_neg(4);
            check($sformatf("R2 vector %0d", v), VEC[v].exp_en);
        end

        // R10 request latency
        reg_en = 8'hFF; map_sel = {3'd5, 3'd4}; req_n = 2'b00; pwr_down = 1'b0;
        wait_neg(4);
        check("R10 steady", 8'hBF);
        req_n = 2'b01;
        wait_neg(2);
        check("R10 not before third edge", 8'hBF);
        wait_neg(1);
        check("R10 on third edge", 8'hAF);
        reg_en = 8'h7F;
        wait_neg(1);
        check("R10 R8 enable one edge", 8'h2F);
        pwr_down = 1'b1;
        wait_neg(1);
        check("R9 pd on", 8'h00);
        pwr_down = 1'b0;
        wait_neg(1);
        check("R9 pd release", 8'h2F);

        // R6 R7 strap captured 1
        reg_en = 8'hFF; req_n = 2'b11;
        do_reset(1'b1);
        wait_neg(1);
        strap_sel = 1'b0;
        wait_neg(4);
        check("R6 R7 strap 1 ignores requests", 8'hFF);
        req_n = 2'b01;
        wait_neg(4);
        check("R6 requests mixed", 8'hFF);
        reg_en = 8'hBF;
        wait_neg(2);
        check("R6 shared follows enable", 8'hBF);

        // R5 strap captured 0 again
        reg_en = 8'hFF; req_n = 2'b11;
        do_reset(1'b0);
        wait_neg(4);
        check("R5 shared off", 8'h8F);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule